// File: doc/BRIEF.md
# Shared-Bus Request/Grant Arbiter with Idle-Grant Detection and Preemption

This block decides which agent on a shared parallel bus may drive the next transaction. Several external masters and one internal requester belonging to the bridge each present an active-low request line and receive an active-low grant line. Only one grant is active at a time. Priority rotates, so the agent granted most recently drops to the back of the queue. The arbiter watches the bus framing and initiator-ready strobes for two purposes: to see when a granted agent has actually started a transaction, and to tell whether the bus is idle.

Two mechanisms bound how long one agent can keep the bus. The first is an idle-grant watchdog. It flags an agent that holds the grant on an idle bus but never starts a transaction. Depending on configuration, that agent is then shut out of arbitration either briefly or until it drops its request. The second is a preemption timer, programmed in units of `PRE_SCALE` clocks. When it runs out, the grant either passes to a waiting agent or, in automatic mode, is withdrawn for one clock and then arbitrated again. When nobody requests, the grant is parked either on the last holder or on the bridge's own requester.

The agent index runs from 0 to `N_EXT`. Index `N_EXT` is the bridge's own requester. All configuration inputs are expected to read 0 after reset.

Top module: `rg_arbiter`

## Requirements
- R1: While rst_n is low every grant output is high. On the first clock edge after reset is released with no request pending, the grant goes to the bridge requester (index N_EXT).
- R2: At most one grant output is low in any cycle.
- R3: When the holder raises its request and other agents are requesting, the grant moves on the next edge to the first requester found by counting upward from the holder's index and wrapping from N_EXT to 0.
- R4: A holder that keeps requesting keeps the grant while other agents request, as long as neither the idle watchdog nor the preemption timer has fired.
- R5: With no request pending, park-select 0 leaves the grant with the last holder and park-select 1 moves it to the bridge requester on the next edge.
- R6: A transaction start is FRAME# low in a cycle whose previous cycle had FRAME# and IRDY# both high, while the grant is held. A holder that sees 17 consecutive cycles of held grant, idle bus and no start since its grant is broken. If another agent is then requesting, the grant moves to it on the next edge. A start before that point prevents the detection.
- R7: With automatic preemption off and no other requester, a broken holder keeps its grant.
- R8: With the broken-master enable at 1, a broken agent's request is ignored until that agent raises its request line.
- R9: With the broken-master enable at 0, a broken agent's request is ignored for only the two cycles that follow detection.
- R10: With a timer value T other than 0, the timer fires once a grant has been held for T*PRE_SCALE+1 cycles. With automatic preemption off, the grant then moves if another agent requests and stays otherwise, and it is never withdrawn with all grants high. T = 0 disables the timer.
- R11: With automatic preemption on, a fired timer raises all grants for exactly one cycle. The grant then goes to the next round-robin requester other than the old holder, or back to the old holder if no other agent requests.
- R12: With automatic preemption on, broken-master detection also causes a one-cycle withdrawal, even when no other agent requests.
- R13: The idle count and the preemption count restart whenever a grant is issued, including a re-grant to the same agent after a withdrawal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | N_EXT+1 | Active-low requests; top index is the bridge requester |
| frame_n | input | 1 | Bus framing strobe, active low |
| irdy_n | input | 1 | Bus initiator-ready strobe, active low |
| cfg_brk_en | input | 1 | 1: broken agent excluded until it releases; 0: excluded two cycles |
| cfg_auto_pre | input | 1 | 1: timer expiry or broken detection withdraws the grant for one cycle |
| cfg_park_bridge | input | 1 | 1: park on bridge requester; 0: park on last holder |
| cfg_pre_time | input | 4 | Preemption time in units of PRE_SCALE clocks; 0 disables |
| gnt_n | output | N_EXT+1 | Active-low grants, registered |

## Verification
The hardest situations to reach are the exclusion windows that follow broken-master detection. They only become visible when a second agent is granted and then releases while the broken agent is still requesting. The stimulus grants one master, adds a competing request, and keeps the bus idle for exactly 17 cycles. It then withdraws the competitor's request on the very cycle the grant moves. This shows the excluded master being passed over for exactly two cycles in one mode and until its own release in the other. The one-cycle withdrawal is reached by programming a short timer, or by letting the idle watchdog expire with automatic preemption enabled.

// File: rtl/rg_pkg.sv
package rg_pkg;
  // Decision taken by the arbiter in one cycle
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_GRANT = 2'd1,
    ACT_DROP  = 2'd2
  } rg_act_e;

  // Width of the programmable preemption time
  localparam int PRE_W = 4;

  // Cycles a broken agent is skipped when hard exclusion is off
  localparam logic [1:0] SOFT_SKIP = 2'd2;
endpackage

// File: rtl/rg_rr_pick.sv
module rg_rr_pick #(
  parameter int NA = 5,
  localparam int IW = (NA > 1) ? $clog2(NA) : 1
) (
  input  logic [NA-1:0] mask,
  input  logic [IW-1:0] last,
  output logic [IW-1:0] pick,
  output logic          any
);
  always_comb begin
    int idx;
    logic found;
    pick  = last;
    found = 1'b0;
    any   = |mask;
    for (int k = 1; k <= NA; k++) begin
      idx = (int'(last) + k) % NA;
      if (!found && mask[idx]) begin
        pick  = IW'(idx);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rg_timers.sv
module rg_timers import rg_pkg::*; #(
  parameter int IDLE_LIMIT = 16,
  parameter int PRE_SCALE  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gnt_on,
  input  logic             new_grant,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic [PRE_W-1:0] pre_time,
  output logic             broken,
  output logic             expired
);
  localparam int ICW  = $clog2(IDLE_LIMIT + 2);
  localparam int PMAX = ((1 << PRE_W) - 1) * PRE_SCALE;
  localparam int PCW  = $clog2(PMAX + 1);

  logic [ICW-1:0] idle_cnt, idle_nxt;
  logic [PCW-1:0] pre_cnt, pre_nxt, pre_lim;
  logic           seen, seen_nxt;
  logic           frame_q, irdy_q;
  logic           bus_idle, start;

  always_comb begin
    bus_idle = frame_n && irdy_n;
    start    = gnt_on && !frame_n && frame_q && irdy_q;
    pre_lim  = PCW'(pre_time) * PCW'(PRE_SCALE);
    expired  = gnt_on && (pre_time != '0) && (pre_cnt >= pre_lim);
    broken   = gnt_on && !seen && bus_idle && (idle_cnt == ICW'(IDLE_LIMIT));

    idle_nxt = idle_cnt;
    pre_nxt  = pre_cnt;
    seen_nxt = seen;
    if (new_grant) begin
      idle_nxt = '0;
      pre_nxt  = '0;
      seen_nxt = 1'b0;
    end else if (gnt_on) begin
      if (pre_cnt < PCW'(PMAX)) pre_nxt = pre_cnt + 1'b1;
      if (start) seen_nxt = 1'b1;
      if (!seen && bus_idle && idle_cnt <= ICW'(IDLE_LIMIT))
        idle_nxt = idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      pre_cnt  <= '0;
      seen     <= 1'b0;
      frame_q  <= 1'b1;
      irdy_q   <= 1'b1;
    end else begin
      idle_cnt <= idle_nxt;
      pre_cnt  <= pre_nxt;
      seen     <= seen_nxt;
      frame_q  <= frame_n;
      irdy_q   <= irdy_n;
    end
  end

  // R13: a fresh grant starts with both counts cleared
  a_r13_idle_restart: assert property (@(posedge clk) disable iff (!rst_n)
    new_grant |=> !broken);
  a_r13_pre_restart: assert property (@(posedge clk) disable iff (!rst_n)
    new_grant |=> !expired);
endmodule

// File: rtl/rg_excl.sv
module rg_excl import rg_pkg::*; #(
  parameter int NA = 5,
  localparam int IW = (NA > 1) ? $clog2(NA) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NA-1:0] req_n,
  input  logic          broken,
  input  logic [IW-1:0] owner,
  input  logic          brk_en,
  output logic [NA-1:0] excl
);
  for (genvar i = 0; i < NA; i++) begin : g_agent
    logic       hard_q, hard_d;
    logic [1:0] soft_q, soft_d;
    logic       hit;

    always_comb begin
      hit    = broken && (owner == IW'(i));
      hard_d = hard_q;
      soft_d = soft_q;
      if (req_n[i])           hard_d = 1'b0;
      else if (hit && brk_en) hard_d = 1'b1;
      if (hit && !brk_en)      soft_d = SOFT_SKIP;
      else if (soft_q != 2'd0) soft_d = soft_q - 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hard_q <= 1'b0;
        soft_q <= 2'd0;
      end else begin
        hard_q <= hard_d;
        soft_q <= soft_d;
      end
    end

    assign excl[i] = hard_q | (soft_q != 2'd0);

    // R8: raising the request always ends hard exclusion
    a_r8_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
      req_n[i] |=> !hard_q);
  end
endmodule

// File: rtl/rg_arbiter.sv
module rg_arbiter import rg_pkg::*; #(
  parameter int N_EXT      = 4,
  parameter int IDLE_LIMIT = 16,
  parameter int PRE_SCALE  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT:0]   req_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             cfg_brk_en,
  input  logic             cfg_auto_pre,
  input  logic             cfg_park_bridge,
  input  logic [PRE_W-1:0] cfg_pre_time,
  output logic [N_EXT:0]   gnt_n
);
  localparam int NA = N_EXT + 1;
  localparam int IW = (NA > 1) ? $clog2(NA) : 1;
  localparam logic [IW-1:0] BRIDGE = IW'(NA - 1);

  logic          gnt_on, nxt_on;
  logic [IW-1:0] owner, nxt_owner, tgt, pick;
  logic [NA-1:0] excl, req_eff, owner_oh, nxt_gnt_n;
  logic          any_req, others, owner_req, owner_raw;
  logic          broken, expired, new_grant;
  rg_act_e       act;

  rg_rr_pick #(.NA(NA)) u_pick (
    .mask (req_eff),
    .last (owner),
    .pick (pick),
    .any  (any_req)
  );

  rg_timers #(.IDLE_LIMIT(IDLE_LIMIT), .PRE_SCALE(PRE_SCALE)) u_timers (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt_on    (gnt_on),
    .new_grant (new_grant),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .pre_time  (cfg_pre_time),
    .broken    (broken),
    .expired   (expired)
  );

  rg_excl #(.NA(NA)) u_excl (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_n  (req_n),
    .broken (broken),
    .owner  (owner),
    .brk_en (cfg_brk_en),
    .excl   (excl)
  );

  // Decision for this cycle
  always_comb begin
    owner_oh  = NA'(1) << owner;
    req_eff   = ~req_n & ~excl;
    others    = |(req_eff & ~owner_oh);
    owner_req = |(req_eff & owner_oh);
    owner_raw = |(~req_n & owner_oh);
    act       = ACT_HOLD;
    tgt       = owner;
    if (!gnt_on) begin
      act = ACT_GRANT;
      if (any_req)              tgt = pick;
      else if (cfg_park_bridge) tgt = BRIDGE;
    end else if (cfg_auto_pre && (expired || broken)) begin
      act = ACT_DROP;
    end else if (others && (expired || broken || !owner_req)) begin
      act = ACT_GRANT;
      tgt = pick;
    end else if (!others && !owner_raw && cfg_park_bridge && owner != BRIDGE) begin
      act = ACT_GRANT;
      tgt = BRIDGE;
    end
  end

  assign new_grant = (act == ACT_GRANT);

  // Next state
  always_comb begin
    nxt_on    = gnt_on;
    nxt_owner = owner;
    case (act)
      ACT_GRANT: begin
        nxt_on    = 1'b1;
        nxt_owner = tgt;
      end
      ACT_DROP: nxt_on = 1'b0;
      default: ;
    endcase
    nxt_gnt_n = ~(nxt_on ? (NA'(1) << nxt_owner) : NA'(0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_on <= 1'b0;
      owner  <= BRIDGE;
      gnt_n  <= '1;
    end else begin
      gnt_on <= nxt_on;
      owner  <= nxt_owner;
      gnt_n  <= nxt_gnt_n;
    end
  end

  // R2: never two grants at once
  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));
  // R11: an all-high grant vector lasts one cycle only
  a_r11_one_cycle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (&gnt_n) |=> !(&gnt_n));
  // R10: without automatic preemption a held grant is never withdrawn
  a_r10_no_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_auto_pre && !(&gnt_n)) |=> !(&gnt_n));
endmodule

// File: tb/test_rg_arbiter.sv
module test_rg_arbiter;
  localparam int NA = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NA-1:0] req_n;
  logic          frame_n, irdy_n;
  logic          cfg_brk_en, cfg_auto_pre, cfg_park_bridge;
  logic [3:0]    cfg_pre_time;
  logic [NA-1:0] gnt_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rg_arbiter #(.N_EXT(NA-1), .IDLE_LIMIT(16), .PRE_SCALE(8)) i_rg_arbiter (
    .clk (clk), .rst_n (rst_n), .req_n (req_n), .frame_n (frame_n), .irdy_n (irdy_n),
    .cfg_brk_en (cfg_brk_en), .cfg_auto_pre (cfg_auto_pre),
    .cfg_park_bridge (cfg_park_bridge), .cfg_pre_time (cfg_pre_time), .gnt_n (gnt_n)
  );

  function automatic int holder(input logic [NA-1:0] g);
    int h = -1;
    for (int i = 0; i < NA; i++) if (!g[i]) h = i;
    return h;
  endfunction

  function automatic int rr_exp(input int h, input logic [NA-1:0] p);
    for (int k = 1; k <= NA; k++) begin
      int i = (h + k) % NA;
      if (p[i]) return i;
    end
    return h;
  endfunction

  // advance one cycle; sample at the falling edge; R2 checked every cycle
  task automatic tick();
    @(negedge clk);
    checks++;
    if ($countones(~gnt_n) > 1) begin
      errors++;
      $display("FAIL R2 grants %b expected at most one low", gnt_n);
    end
  endtask

  task automatic chk(input int exp, input string tag);
    checks++;
    if (holder(gnt_n) != exp) begin
      errors++;
      $display("FAIL %s holder %0d expected %0d", tag, holder(gnt_n), exp);
    end
  endtask

  task automatic reqs(input logic [NA-1:0] a);
    req_n = ~a;
  endtask

  initial begin
    repeat (6000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_n = '1; frame_n = 1'b1; irdy_n = 1'b1;
    cfg_brk_en = 1'b0; cfg_auto_pre = 1'b0; cfg_park_bridge = 1'b0; cfg_pre_time = 4'd0;
    repeat (3) tick();
    checks++;
    if (gnt_n !== '1) begin
      errors++;
      $display("FAIL R1 reset grants %b expected %b", gnt_n, {NA{1'b1}});
    end
    rst_n = 1'b1;
    tick(); chk(NA-1, "R1 first grant to bridge");

    // R3 sweep: every holder against every pattern of other requesters
    for (int h = 0; h < NA; h++) begin
      for (int p = 1; p < (1 << NA); p++) begin
        if (p[h]) continue;
        reqs(NA'(1) << h); tick(); chk(h, "R3 set holder");
        reqs(NA'(p));      tick(); chk(rr_exp(h, NA'(p)), "R3 rotate");
      end
    end

    // R4 and R6 negative: holder starts a transaction and keeps requesting
    reqs(5'b00001); tick(); chk(0, "R4 grant");
    reqs(5'b00111); frame_n = 1'b0;
    tick(); frame_n = 1'b1; chk(0, "R4 hold");
    for (int k = 0; k < 30; k++) begin tick(); chk(0, "R4 R6 started holder kept"); end

    // R5 parking
    cfg_park_bridge = 1'b1; reqs('0);
    tick(); chk(NA-1, "R5 park on bridge");
    cfg_park_bridge = 1'b0; reqs(5'b00100);
    tick(); chk(2, "R5 grant");
    reqs('0);
    for (int k = 0; k < 3; k++) begin tick(); chk(2, "R5 park on last"); end

    // R6 broken detection then R9 two-cycle skip
    reqs(5'b00010); tick(); chk(1, "R6 grant");
    reqs(5'b01010);
    for (int k = 1; k <= 16; k++) begin tick(); chk(1, "R6 idle holder kept"); end
    tick(); chk(3, "R6 broken moves grant");
    reqs(5'b00010);
    tick(); chk(3, "R9 skip cycle one");
    tick(); chk(3, "R9 skip cycle two");
    tick(); chk(1, "R9 skip lapses");

    // R8 hard exclusion until release
    cfg_brk_en = 1'b1;
    reqs(5'b00001); tick(); chk(0, "R8 setup");
    reqs(5'b00010); tick(); chk(1, "R8 grant");
    reqs(5'b01010);
    for (int k = 1; k <= 16; k++) begin tick(); chk(1, "R8 idle holder kept"); end
    tick(); chk(3, "R8 broken moves grant");
    reqs(5'b00010);
    for (int k = 0; k < 5; k++) begin tick(); chk(3, "R8 broken agent ignored"); end
    reqs('0);       tick(); chk(3, "R8 release");
    reqs(5'b00010); tick(); chk(1, "R8 competes after release");

    // R7 broken, no competitor, automatic preemption off
    for (int k = 0; k < 25; k++) begin tick(); chk(1, "R7 broken holder kept"); end

    // R10 timer with automatic preemption off
    cfg_brk_en = 1'b0; cfg_pre_time = 4'd1;
    reqs(5'b00001); tick(); chk(0, "R10 grant");
    reqs(5'b00011); frame_n = 1'b0;
    tick(); frame_n = 1'b1; chk(0, "R10 before expiry");
    for (int k = 2; k <= 8; k++) begin tick(); chk(0, "R10 before expiry"); end
    tick(); chk(1, "R10 expiry moves grant");
    reqs(5'b00010);
    for (int k = 0; k < 20; k++) begin tick(); chk(1, "R10 expired holder kept"); end

    // R11 automatic preemption and R13 restart
    reqs(5'b00100); tick(); chk(2, "R11 grant");
    cfg_auto_pre = 1'b1;
    for (int k = 1; k <= 8; k++) begin tick(); chk(2, "R11 before expiry"); end
    tick(); chk(-1, "R11 one-cycle withdrawal");
    tick(); chk(2, "R11 same holder regranted");
    reqs(5'b01100);
    for (int k = 1; k <= 8; k++) begin tick(); chk(2, "R13 timer restarted"); end
    tick(); chk(-1, "R11 withdrawal with competitor");
    tick(); chk(3, "R11 next requester granted");

    // R12 broken with automatic preemption on
    cfg_pre_time = 4'd0; reqs(5'b00001);
    tick(); chk(0, "R12 grant");
    for (int k = 1; k <= 16; k++) begin tick(); chk(0, "R12 idle holder kept"); end
    tick(); chk(-1, "R12 withdrawal on broken");
    tick(); chk(0, "R12 regrant");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule